// File: doc/BRIEF.md
# Signed Floored Modulo Pipeline

This block reduces a signed 16-bit operand modulo a fixed positive constant. It returns the floored remainder, which always lies between 0 and MODULUS-1, including for negative operands. This is the convention numerical tools use, and it differs from the HDL `%` operator, whose result takes the sign of the dividend. A valid strobe travels with each operand, and the matching result appears a fixed number of cycles later. A new operand may enter on every clock.

The modulus is a build-time parameter. A negative operand is first lifted into the non-negative range by adding a multiple of the modulus, which is worked out at elaboration. The lifted value then passes through a chain of compare-and-subtract steps against the modulus shifted left by a falling amount. Pipeline registers split the chain into groups of `SUBS_PER_REG` steps, so each register-to-register path holds only a few narrow subtractors. This lets the chain meet a 12.5 ns cycle, where a single combinational reduction of about 43 ns would not.

Top module: `fmod_top`

## Requirements
- R1: Whenever `oValid` is high, `oRemainder` equals ((y % M) + M) % M, where y is the operand taken as 16-bit two's complement and M is MODULUS, and it is always below M.
- R2: A negative operand gives the non-negative floored remainder. With M=6434, an operand of -6310 gives 124. With M=12868, the same operand gives 6558.
- R3: `oValid` rises exactly LATENCY clocks after the rising edge on which `iValid` was sampled high. LATENCY = 1 + ceil((S+1)/SUBS_PER_REG), where S is the largest shift with M<<S not above the largest lifted value. This gives LATENCY=4 for M=12868 with one step per register, and LATENCY=3 for M=6434 with two steps per register.
- R4: Operands presented on consecutive cycles come out on consecutive cycles, in order, with no lost or merged results.
- R5: `rst` is synchronous and active high. While it is sampled high, and for every operand already in flight when it is sampled, no `oValid` is produced.
- R6: A cycle with `iValid` low produces no result, so gaps in the input stream reappear as gaps in `oValid` exactly LATENCY cycles later.
- R7: The extreme operands reduce correctly with M=12868: -32768 gives 5836, -1 gives 12867, 0 gives 0, 12867 gives 12867, 12868 gives 0, and 32767 gives 7031.
- R8: The same RTL gives correct results when MODULUS is set to 6434 and SUBS_PER_REG to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| iValid | input | 1 | Operand qualifier |
| iOperand | input | IN_W (16) | Two's-complement dividend |
| oValid | output | 1 | Result qualifier, LATENCY cycles after `iValid` |
| oRemainder | output | OUT_W (15) | Floored remainder, 0 to MODULUS-1 |

## Verification
The hardest situation to reach is a reset that arrives while operands are part-way through the subtraction chain. Operands that are already lifted and partly reduced must vanish, and the pipeline must not leak stale data once the stream restarts. The stimulus keeps the stream running back to back, raises `rst` for two cycles in the middle of it, then resumes at once. The bench compares each cycle against a reference in which any operand that meets a reset cycle is dropped. Two instances with different moduli and different register grouping receive the same stream, so a latency or grouping error shows up in at least one of them.

// File: rtl/fmod_pkg.sv
package fmod_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic takeIn;   // capture the lifted operand into the first register
  } fmod_strobe_t;

  // Number of modulus copies needed to lift the most negative operand to >= 0.
  function automatic int fmBiasMult(input int modulus, input int inW);
    return ((1 << (inW - 1)) + modulus - 1) / modulus;
  endfunction

  // Largest value the lifted operand can take.
  function automatic int fmMaxSum(input int modulus, input int inW);
    return (1 << (inW - 1)) - 1 + fmBiasMult(modulus, inW) * modulus;
  endfunction

  // Width of the lifted operand; always strictly wider than the input.
  function automatic int fmSumWidth(input int modulus, input int inW);
    int w;
    w = $clog2(fmMaxSum(modulus, inW) + 1);
    return (w > inW) ? w : inW + 1;
  endfunction

  // Largest shift k such that modulus << k does not exceed the lifted maximum.
  function automatic int fmTopShift(input int modulus, input int inW);
    int k;
    longint lim;
    k = 0;
    lim = longint'(fmMaxSum(modulus, inW));
    for (int i = 1; i < 40; i++) begin
      if ((longint'(modulus) << i) <= lim) k = i;
    end
    return k;
  endfunction

  // Number of pipeline registers after the lifting register.
  function automatic int fmChainRegs(input int modulus, input int inW, input int perReg);
    return (fmTopShift(modulus, inW) + perReg) / perReg;
  endfunction

  function automatic int fmLatency(input int modulus, input int inW, input int perReg);
    return 1 + fmChainRegs(modulus, inW, perReg);
  endfunction

endpackage

// File: rtl/fmod_ctrl.sv
module fmod_ctrl #(
  parameter int NPIPE = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      iValid,
  output fmod_pkg::fmod_strobe_t    stb,
  output logic [NPIPE-1:0]          stageVld
);

  // Only qualified operands disturb the first data register.
  always_comb begin
    stb.takeIn = iValid;
  end

  // One valid bit per pipeline register; bit 0 belongs to the lifting register.
  always_ff @(posedge clk) begin
    if (rst) begin
      stageVld <= '0;
    end else begin
      stageVld <= {stageVld[NPIPE-2:0], iValid};
    end
  end

endmodule

// File: rtl/fmod_dpath.sv
module fmod_dpath #(
  parameter int IN_W         = 16,
  parameter int OUT_W        = 15,
  parameter int MODULUS      = 12868,
  parameter int SUBS_PER_REG = 1,
  localparam int SUM_W  = fmod_pkg::fmSumWidth(MODULUS, IN_W),
  localparam int BIAS   = fmod_pkg::fmBiasMult(MODULUS, IN_W) * MODULUS,
  localparam int KTOP   = fmod_pkg::fmTopShift(MODULUS, IN_W),
  localparam int NSUB   = KTOP + 1,
  localparam int NPIPE  = fmod_pkg::fmLatency(MODULUS, IN_W, SUBS_PER_REG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  fmod_pkg::fmod_strobe_t    stb,
  input  logic [NPIPE-1:0]          stageVld,
  input  logic [IN_W-1:0]           iOperand,
  output logic [OUT_W-1:0]          oRemainder
);

  logic [SUM_W-1:0]            lifted;
  logic [SUM_W-1:0]            liftReg;
  logic [NSUB:0][SUM_W-1:0]    link;

  // Sign-extend and add the bias; the true sum always fits in SUM_W bits.
  always_comb begin
    lifted = {{(SUM_W-IN_W){iOperand[IN_W-1]}}, iOperand} + SUM_W'(BIAS);
  end

  always_ff @(posedge clk) begin
    if (stb.takeIn) liftReg <= lifted;
  end

  assign link[0] = liftReg;

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    localparam int KSH = KTOP - s;
    localparam logic [SUM_W-1:0] STEP = SUM_W'(longint'(MODULUS) << KSH);
    localparam int SRC = s / SUBS_PER_REG;            // register feeding this group
    localparam bit ENDS_GROUP = ((s + 1) % SUBS_PER_REG == 0) || (s == NSUB - 1);

    logic [SUM_W-1:0] stOut;

    always_comb begin
      if (link[s] >= STEP) stOut = link[s] - STEP;
      else                 stOut = link[s];
    end

    if (ENDS_GROUP) begin : g_reg
      logic [SUM_W-1:0] held;
      always_ff @(posedge clk) begin
        if (stageVld[SRC]) held <= stOut;
      end
      assign link[s+1] = held;
    end else begin : g_wire
      assign link[s+1] = stOut;
    end

    // After this step the partial value is below the shifted modulus it used.
    AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (rst)
      stageVld[SRC] |-> (stOut < STEP)); // R1
  end

  assign oRemainder = link[NSUB][OUT_W-1:0];

  // The final value fits the result port: no bits are lost by the slice.
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    stageVld[NPIPE-1] |-> (link[NSUB][SUM_W-1:OUT_W] == '0)); // R1

  // The lifted operand never reaches the range that the first step cannot reduce.
  AST_LIFT_BOUND: assert property (@(posedge clk) disable iff (rst)
    stageVld[0] |-> (liftReg < SUM_W'(2 * (longint'(MODULUS) << KTOP)))); // R2

endmodule

// File: rtl/fmod_top.sv
module fmod_top #(
  parameter int IN_W         = 16,
  parameter int OUT_W        = 15,
  parameter int MODULUS      = 12868,
  parameter int SUBS_PER_REG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iValid,
  input  logic [IN_W-1:0]   iOperand,
  output logic              oValid,
  output logic [OUT_W-1:0]  oRemainder
);

  localparam int LATENCY = fmod_pkg::fmLatency(MODULUS, IN_W, SUBS_PER_REG);

  fmod_pkg::fmod_strobe_t stb;
  logic [LATENCY-1:0]     stageVld;

  fmod_ctrl #(
    .NPIPE (LATENCY)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .iValid   (iValid),
    .stb      (stb),
    .stageVld (stageVld)
  );

  fmod_dpath #(
    .IN_W         (IN_W),
    .OUT_W        (OUT_W),
    .MODULUS      (MODULUS),
    .SUBS_PER_REG (SUBS_PER_REG)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .stageVld   (stageVld),
    .iOperand   (iOperand),
    .oRemainder (oRemainder)
  );

  assign oValid = stageVld[LATENCY-1];

  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
    oValid |-> (int'(oRemainder) < MODULUS)); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !oValid); // R5

endmodule

// File: tb/sim_fmod_top.sv
`timescale 1ns/1ps
module sim_fmod_top;

  localparam int  M0 = 12868;
  localparam int  M1 = 6434;
  localparam int  LAT0 = 4;   // from R3
  localparam int  LAT1 = 3;   // from R3
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iValid = 1'b0;
  logic [15:0] iOperand = '0;
  logic        oValid0, oValid1;
  logic [14:0] oRem0, oRem1;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit    v;
    bit    r;
    int    d;
    string tag;
  } ent_t;
  ent_t hist[$];

  always #(HALF) clk = ~clk;

  fmod_top #(.MODULUS(M0), .SUBS_PER_REG(1)) u0 (
    .clk(clk), .rst(rst), .iValid(iValid), .iOperand(iOperand),
    .oValid(oValid0), .oRemainder(oRem0));

  fmod_top #(.MODULUS(M1), .SUBS_PER_REG(2)) u1 (
    .clk(clk), .rst(rst), .iValid(iValid), .iOperand(iOperand),
    .oValid(oValid1), .oRemainder(oRem1));

  function automatic int floorMod(int y, int m);
    return ((y % m) + m) % m;
  endfunction

  task automatic checkOne(int lat, int m, logic ov, logic [14:0] orem, string who);
    int  e;
    bit  expV;
    bit  killed;
    string vtag;
    e = hist.size() - lat;
    expV = 1'b0;
    killed = 1'b0;
    if (e >= 0) begin
      expV = hist[e].v;
      for (int j = e; j < hist.size(); j++) if (hist[j].r) killed = 1'b1;
      if (killed) expV = 1'b0;
    end
    if (killed) vtag = "R5";
    else if (expV) vtag = "R3";
    else vtag = "R6";
    checks++;
    if (ov !== expV) begin
      fails++;
      $display("FAIL %s %s valid: actual %0b expected %0b", vtag, who, ov, expV);
    end else if (expV) begin
      int want;
      want = floorMod(hist[e].d, m);
      checks++;
      if (int'(orem) !== want) begin
        fails++;
        $display("FAIL %s %s operand %0d: actual %0d expected %0d",
                 hist[e].tag, who, hist[e].d, orem, want);
      end
    end
  endtask

  // Check outputs of the edge just passed, then drive the next cycle.
  task automatic step(bit v, int d, string tag, bit r);
    ent_t en;
    @(negedge clk);
    checkOne(LAT0, M0, oValid0, oRem0, "u0");
    checkOne(LAT1, M1, oValid1, oRem1, "u1 (R8)");
    rst      = r;
    iValid   = v;
    iOperand = d[15:0];
    en.v = v; en.r = r; en.d = d; en.tag = tag;
    hist.push_back(en);
    if (hist.size() > 40) void'(hist.pop_front());
  endtask

  function automatic int rnd16();
    int x;
    x = int'($urandom_range(0, 65535));
    return (x >= 32768) ? x - 65536 : x;
  endfunction

  initial begin
    // Reset phase (R5): nothing valid may leave.
    for (int i = 0; i < 4; i++) step(1'b1, rnd16(), "R5", 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 0, "R6", 1'b0);

    // Boundary operands (R7) and the negative example (R2).
    step(1'b1, -32768, "R7", 1'b0);
    step(1'b1, -1,     "R7", 1'b0);
    step(1'b1, 0,      "R7", 1'b0);
    step(1'b1, 12867,  "R7", 1'b0);
    step(1'b1, 12868,  "R7", 1'b0);
    step(1'b1, 32767,  "R7", 1'b0);
    step(1'b1, -6310,  "R2", 1'b0);
    step(1'b1, 6433,   "R2", 1'b0);
    step(1'b1, 6434,   "R2", 1'b0);
    step(1'b1, -6434,  "R2", 1'b0);
    step(1'b1, -6435,  "R2", 1'b0);
    step(1'b1, -12868, "R2", 1'b0);
    step(1'b1, -12869, "R2", 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 0, "R6", 1'b0);

    // Back-to-back random stream (R4, R1).
    for (int i = 0; i < 400; i++) step(1'b1, rnd16(), "R4", 1'b0);

    // Sparse stream with gaps (R6, R1).
    for (int i = 0; i < 400; i++) begin
      bit v;
      v = bit'($urandom_range(0, 1));
      step(v, rnd16(), v ? "R1" : "R6", 1'b0);
    end

    // Reset in the middle of a full pipeline, then resume at once (R5).
    for (int i = 0; i < 10; i++) step(1'b1, rnd16(), "R5", 1'b0);
    step(1'b1, rnd16(), "R5", 1'b1);
    step(1'b1, rnd16(), "R5", 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, rnd16(), "R5", 1'b0);

    // Drain.
    for (int i = 0; i < 8; i++) step(1'b0, 0, "R6", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(2.0 * HALF * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule